// File: doc/BRIEF.md
# Frame-Pattern Word Aligner

This block sits behind a 1:8 deserializer on a source-synchronous DDR receiver. Every lane delivers one 8-bit word per slow-clock cycle, which is one quarter of the fast bit clock. One extra lane carries the sampled frame clock. When the word boundary is right, that lane reads `11110000`. The aligner keeps the previous word of every lane next to the current one. It cuts an 8-bit window out of that pair at a slip offset that all lanes share. It moves the offset one bit at a time until the reference window shows the frame pattern.

Alignment starts only once an upstream capture stage reports that every bit is sampled at mid-eye. After each slip the block waits a fixed number of cycles before it looks at the pattern again. The block signals when it is aligned. It raises a sticky error when eight slips in a row fail, and it drops the aligned flag if the pattern is lost for several words in a row. Data leaves MSB first, one register after the window.

Top module: `frame_bitslip_aligner`

## Requirements
- R1: After reset, and on every edge where `capture_locked_i` is low, the block is idle. `aligned_o` and `error_o` are 0 and the slip offset is 0. Each output lane then equals its input word from the previous edge, unrotated, and `data_o` is 0 during reset.
- R2: For offset k, each lane's window is bits [k+7:k] of the 16-bit pair {previous word, current word}, and every lane uses the same k. `data_o` lane j occupies bits [8j+7:8j] and is registered one cycle after its input word.
- R3: The reference window matches when it equals 8'b11110000. A match seen in the checking state sets `aligned_o` on that edge, and no further slip happens. Without a match, `aligned_o` does not rise.
- R4: A mismatch seen in the checking state causes exactly one slip. The offset rises by one, and it wraps from 7 to 0.
- R5: After each slip the block spends SETTLE_CYCLES (default 4) edges waiting before it checks again. If the input is held steady and k slips are needed, `aligned_o` rises on edge 2 + k*(2+SETTLE_CYCLES) counted from the first edge that sees `capture_locked_i` high.
- R6: The eighth consecutive slip without alignment sets `error_o`, on the edge of that slip. The search keeps going after that. `error_o` stays set, even through a later alignment, until `capture_locked_i` goes low or reset is applied.
- R7: While aligned, fewer than 4 consecutive mismatching reference windows leave `aligned_o` at 1. The 4th consecutive mismatch clears it on that edge and restarts the search.
- R8: After alignment, a transmitter word sent MSB first appears whole on every data lane, in MSB-to-LSB order and not rotated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | slow (word) clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| capture_locked_i | input | 1 | per-bit capture is centred; low holds the block idle |
| ref_word_i | input | 8 | deserialized frame-clock lane |
| data_i | input | LANES*8 | deserialized data lanes, lane j at [8j+7:8j] |
| data_o | output | LANES*8 | aligned data lanes, MSB first |
| aligned_o | output | 1 | word boundary found |
| error_o | output | 1 | sticky: eight consecutive slips failed |

## Verification
A data word is due on `data_o` one edge after it is applied. `aligned_o` rises on edge 2 + k*(2+SETTLE_CYCLES) after lock is seen, and the eighth failed slip shows on `error_o` at edge 45. A loss of alignment shows on the edge of the fourth bad reference word. The bench drives all inputs on the falling edge and counts rising edges. It samples on the next falling edge, so every expected value is compared at the exact edge it is due, plus the edge just before it.

// File: rtl/bitslip_align_pkg.sv
package bitslip_align_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SLIP,
    ST_WAIT,
    ST_ALIGNED
  } align_state_e;
endpackage

// File: rtl/word_slicer.sv
module word_slicer #(
  parameter int W     = 8,
  parameter int OFS_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     word_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [W-1:0]     win_o
);
  // top bit of the previous word is never selected, so it is not stored
  logic [W-2:0]   prev_q;
  logic [2*W-2:0] pair;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= word_i[W-2:0];

  assign pair = {prev_q, word_i};

  always_comb begin
    for (int i = 0; i < W; i++) begin
      int idx;
      idx      = i + int'(ofs_i);
      win_o[i] = pair[idx];
    end
  end
endmodule

// File: rtl/align_fsm.sv
module align_fsm
  import bitslip_align_pkg::*;
#(
  parameter int W             = 8,
  parameter int SETTLE_CYCLES = 4,
  parameter int MAX_SLIPS     = 8,
  parameter int LOSS_LIMIT    = 4,
  parameter int OFS_W         = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             locked_i,
  input  logic             match_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic             aligned_o,
  output logic             error_o
);
  localparam int WAIT_W = $clog2(SETTLE_CYCLES + 1);
  localparam int SLIP_W = $clog2(MAX_SLIPS + 1);
  localparam int MISS_W = $clog2(LOSS_LIMIT + 1);
  localparam logic [OFS_W-1:0]  OFS_MAX   = OFS_W'(W - 1);
  localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(SETTLE_CYCLES - 1);
  localparam logic [SLIP_W-1:0] SLIP_LAST = SLIP_W'(MAX_SLIPS - 1);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_LIMIT - 1);

  align_state_e      state_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [WAIT_W-1:0] wait_q;
  logic [SLIP_W-1:0] slip_q;
  logic [MISS_W-1:0] miss_q;
  logic              aligned_q, error_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; ofs_q <= '0; wait_q <= '0; slip_q <= '0;
      miss_q <= '0; aligned_q <= 1'b0; error_q <= 1'b0;
    end else if (!locked_i) begin
      state_q <= ST_IDLE; ofs_q <= '0; wait_q <= '0; slip_q <= '0;
      miss_q <= '0; aligned_q <= 1'b0; error_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: state_q <= ST_CHECK;
        ST_CHECK:
          if (match_i) begin
            state_q   <= ST_ALIGNED;
            aligned_q <= 1'b1;
            slip_q    <= '0;
            miss_q    <= '0;
          end else begin
            state_q <= ST_SLIP;
          end
        ST_SLIP: begin
          ofs_q   <= (ofs_q == OFS_MAX) ? '0 : ofs_q + 1'b1;
          wait_q  <= WAIT_LOAD;
          state_q <= ST_WAIT;
          if (slip_q == SLIP_LAST) begin
            error_q <= 1'b1;
            slip_q  <= '0;
          end else begin
            slip_q <= slip_q + 1'b1;
          end
        end
        ST_WAIT:
          if (wait_q == '0) state_q <= ST_CHECK;
          else              wait_q  <= wait_q - 1'b1;
        ST_ALIGNED:
          if (match_i) begin
            miss_q <= '0;
          end else if (miss_q == MISS_LAST) begin
            miss_q    <= '0;
            aligned_q <= 1'b0;
            state_q   <= ST_CHECK;
          end else begin
            miss_q <= miss_q + 1'b1;
          end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ofs_o     = ofs_q;
  assign aligned_o = aligned_q;
  assign error_o   = error_q;
endmodule

// File: rtl/frame_bitslip_aligner.sv
module frame_bitslip_aligner #(
  parameter int           LANES         = 4,
  parameter int           W             = 8,
  parameter logic [W-1:0] PATTERN       = 8'b1111_0000,
  parameter int           SETTLE_CYCLES = 4,
  parameter int           MAX_SLIPS     = 8,
  parameter int           LOSS_LIMIT    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_locked_i,
  input  logic [W-1:0]       ref_word_i,
  input  logic [LANES*W-1:0] data_i,
  output logic [LANES*W-1:0] data_o,
  output logic               aligned_o,
  output logic               error_o
);
  localparam int OFS_W = $clog2(W);

  logic [OFS_W-1:0] slip_ofs;
  logic [W-1:0]     ref_win;
  logic             ref_match;

  word_slicer #(.W(W), .OFS_W(OFS_W)) u_ref_slicer (
    .clk_i, .rst_ni, .word_i(ref_word_i), .ofs_i(slip_ofs), .win_o(ref_win)
  );

  assign ref_match = (ref_win == PATTERN);

  align_fsm #(
    .W(W), .SETTLE_CYCLES(SETTLE_CYCLES), .MAX_SLIPS(MAX_SLIPS),
    .LOSS_LIMIT(LOSS_LIMIT), .OFS_W(OFS_W)
  ) u_fsm (
    .clk_i, .rst_ni, .locked_i(capture_locked_i), .match_i(ref_match),
    .ofs_o(slip_ofs), .aligned_o, .error_o
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [W-1:0] win;
    logic [W-1:0] out_q;

    word_slicer #(.W(W), .OFS_W(OFS_W)) u_slicer (
      .clk_i, .rst_ni, .word_i(data_i[j*W +: W]), .ofs_i(slip_ofs), .win_o(win)
    );

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) out_q <= '0;
      else         out_q <= win;

    assign data_o[j*W +: W] = out_q;
  end
endmodule

// File: rtl/aligner_checker.sv
module aligner_checker #(
  parameter int W     = 8,
  parameter int OFS_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             capture_locked_i,
  input logic             aligned_o,
  input logic             error_o,
  input logic [OFS_W-1:0] slip_ofs,
  input logic             ref_match
);
  // R1
  assert_lock_low_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_locked_i |=> (!aligned_o && !error_o && slip_ofs == '0));

  // R4: offset holds or steps by one, wrapping
  assert_single_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_locked_i |=> (slip_ofs == $past(slip_ofs) ||
                          int'(slip_ofs) == (int'($past(slip_ofs)) + 1) % W));

  // R3
  assert_align_needs_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_locked_i && !aligned_o && !ref_match) |=> !aligned_o);

  // R6
  assert_error_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_locked_i && error_o) |=> error_o);

  // R7
  assert_hold_on_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_locked_i && aligned_o && ref_match) |=> aligned_o);
endmodule

bind frame_bitslip_aligner aligner_checker #(.W(W), .OFS_W(OFS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .capture_locked_i(capture_locked_i),
  .aligned_o(aligned_o), .error_o(error_o), .slip_ofs(slip_ofs),
  .ref_match(ref_match)
);

// File: tb/tb_frame_bitslip_aligner.sv
module tb_frame_bitslip_aligner;
  localparam int LANES  = 4;
  localparam int SETTLE = 4;
  localparam logic [7:0] PAT = 8'b1111_0000;

  logic clk = 1'b0, rst_ni = 1'b0, locked = 1'b0;
  logic [7:0] ref_word = '0;
  logic [LANES*8-1:0] din = '0;
  logic [LANES*8-1:0] dout;
  logic aligned, err;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frame_bitslip_aligner #(.LANES(LANES), .SETTLE_CYCLES(SETTLE)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .capture_locked_i(locked),
    .ref_word_i(ref_word), .data_i(din), .data_o(dout),
    .aligned_o(aligned), .error_o(err)
  );

  // {boundary skew s, base data word}
  localparam logic [10:0] VEC [8] = '{
    {3'd0, 8'hA5}, {3'd1, 8'h3C}, {3'd2, 8'h81}, {3'd3, 8'h5E},
    {3'd4, 8'hC7}, {3'd5, 8'h12}, {3'd6, 8'hF9}, {3'd7, 8'h66}
  };

  function automatic logic [7:0] ror8(logic [7:0] x, int n);
    logic [15:0] t;
    t = {x, x} >> n;
    return t[7:0];
  endfunction

  function automatic logic [7:0] lane_word(logic [7:0] base, int j);
    return base ^ 8'(j * 8'h4B);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_skew(int s, logic [7:0] base);
    ref_word = ror8(PAT, s);
    for (int j = 0; j < LANES; j++) din[j*8 +: 8] = ror8(lane_word(base, j), s);
  endtask

  task automatic relock();
    locked = 1'b0;
    tick();
    locked = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    check("R1 data in reset", dout, '0);
    check("R1 aligned in reset", aligned, 0);
    check("R1 error in reset", err, 0);
    rst_ni = 1'b1;
    // R1: lock low, offset 0 pass-through, pattern ignored
    ref_word = PAT;
    din = 32'hDEAD_BEEF;
    tick();
    din = 32'h1234_5678;
    tick();
    check("R1 passthrough", dout, 32'h1234_5678);
    repeat (5) tick();
    check("R1 aligned held low", aligned, 0);

    // table: every skew, alignment time and lane contents (R2 R3 R4 R5 R8)
    for (int v = 0; v < 8; v++) begin
      int s, k, exp_edge, edge_seen;
      s = int'(VEC[v][10:8]);
      k = (8 - s) % 8;
      exp_edge = 2 + k * (2 + SETTLE);
      locked = 1'b0;
      drive_skew(s, VEC[v][7:0]);
      tick();
      locked = 1'b1;
      edge_seen = 0;
      for (int c = 1; c <= 80; c++) begin
        tick();
        if (aligned && edge_seen == 0) edge_seen = c;
      end
      check("R5 align edge", edge_seen, exp_edge);
      check("R6 no error within 7 slips", err, 0);
      for (int j = 0; j < LANES; j++)
        check("R8 lane word", dout[j*8 +: 8], lane_word(VEC[v][7:0], j));
    end

    // R5/R3 exact: one slip (s=7), aligned not before edge 8
    relock();
    drive_skew(7, 8'h0F);
    repeat (7) tick();
    check("R5 still waiting at edge 7", aligned, 0);
    tick();
    check("R3 aligned at edge 8", aligned, 1);

    // R2: streaming words through skew 3 (offset 5), one-cycle latency
    begin
      logic [7:0] prev_t, t;
      relock();
      drive_skew(3, 8'h5E);
      repeat (40) tick();
      check("R3 aligned for stream", aligned, 1);
      prev_t = 8'h5E;
      for (int n = 0; n < 8; n++) begin
        t = 8'(n * 8'h1D + 8'h07);
        din[7:0] = {prev_t[2:0], t[7:3]};
        tick();
        check("R2 stream word", dout[7:0], prev_t);
        prev_t = t;
      end
    end

    // R6: pattern absent, error on 8th slip (edge 45)
    relock();
    ref_word = 8'h55;
    repeat (44) tick();
    check("R6 no error at edge 44", err, 0);
    tick();
    check("R6 error at edge 45", err, 1);
    check("R4 not aligned", aligned, 0);
    repeat (60) tick();
    check("R6 error sticky while cycling", err, 1);
    ref_word = PAT;
    repeat (60) tick();
    check("R6 realigns after error", aligned, 1);
    check("R6 error survives alignment", err, 1);
    locked = 1'b0;
    tick();
    check("R6 error cleared by lock low", err, 0);

    // R7: loss detection at offset 0
    drive_skew(0, 8'h33);
    locked = 1'b1;
    repeat (4) tick();
    check("R7 aligned before loss", aligned, 1);
    ref_word = 8'h00;
    repeat (3) tick();
    check("R7 three misses keep aligned", aligned, 1);
    ref_word = PAT;
    tick();
    ref_word = 8'h00;
    repeat (3) tick();
    check("R7 counter restarted", aligned, 1);
    tick();
    check("R7 fourth miss clears", aligned, 0);

    finish_run();
  end
endmodule